// File: doc/BRIEF.md
# Dual-Protocol Serial Register Write Port

This block is the control slave that lets a host processor load a bank of configuration registers over a few pins. A host sends 24-bit control words serially. The block splits each word into an 8-bit register address, which comes first on the wire, and a 16-bit value. It produces a single-cycle write strobe with that address and value, and stores the value in a small register file. A parallel read port returns what was stored.

A strap pin picks the wire protocol. When the pin is high, the block uses a 3-wire scheme: it shifts bits in while an active-low select is held, and the rising edge of the select commits the word. When the pin is low, it uses a 2-wire scheme with start and stop conditions and a 7-bit device address, and it acknowledges each byte by pulling the shared data line low.

Two pins can become general-purpose inputs. In 2-wire mode the select pin is not needed, so its level is passed out as a plain input. A configuration bit can take over the strap pin as well. While that bit is set, the protocol stays where it was and the strap level is passed out instead. All serial pins are synchronised into the system clock. Line edges are found by comparing successive samples.

Top module: `ctl_serial_slave`

## Requirements
- R1: After reset, `wr_stb_o` and `sda_pull_o` are 0, and every register of the file reads back 0.
- R2: In 3-wire mode (`mode_i` high), bits are taken MSB first on each rising `scl_i` while `csn_i` is low. The first 8 bits are the address and the next 16 bits are the value. On the rising edge of `csn_i`, a word of exactly 24 bits produces one strobe carrying that address and value.
- R3: In 3-wire mode, a select window that ends with any bit count other than 24 produces no strobe and leaves the register file unchanged.
- R4: `proto_3w_o` follows the strap: 1 while `mode_i` is high and 0 while it is low, as long as the override bit is clear.
- R5: In 2-wire mode, a start is a fall of the data line while the clock is high, and a stop is a rise of the data line while the clock is high. The first byte after a start must be the device address `DEV_ADDR` (7 bits) followed by a write bit of 0. When it matches, `sda_pull_o` is 1 from the clock fall after the 8th bit to the clock fall after the 9th.
- R6: In 2-wire mode, three more bytes follow: the address, the value high byte and the value low byte. Each is acknowledged the same way, and the strobe fires once when the last byte has been received.
- R7: In 2-wire mode, a first byte that does not match (wrong address, or a read bit of 1) gets no acknowledge. All later bytes are then ignored, with no acknowledge and no strobe, until the next start.
- R8: A start received in the middle of a 2-wire transfer discards the partial word. The bytes after the new start form the next word.
- R9: `wr_stb_o` is never high for two cycles in a row.
- R10: A write to an address below `NREGS` is readable on `rd_data_o` when `rd_addr_i` equals that address. A write to a higher address changes no register. Reading an address of `NREGS` or more returns 0.
- R11: Bit 0 of register `CFG_ADDR` set to 1 freezes `proto_3w_o` and passes the synchronised `mode_i` level to `mode_gpio_o`. Clearing the bit returns protocol control to the strap, and `mode_gpio_o` is then 0.
- R12: In 2-wire mode, `cs_gpio_o` is the synchronised `csn_i` level and `csn_i` has no effect on transfers. In 3-wire mode, `cs_gpio_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock |
| sda_i | input | 1 | Serial data line level |
| csn_i | input | 1 | Active-low select in 3-wire mode; general input in 2-wire mode |
| mode_i | input | 1 | Protocol strap (1 = 3-wire, 0 = 2-wire) or general input |
| sda_pull_o | output | 1 | Drive the data line low (acknowledge) |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8 | Register address of the strobed word |
| wr_data_o | output | 16 | Value of the strobed word |
| rd_addr_i | input | 8 | Readback address |
| rd_data_o | output | 16 | Readback value |
| proto_3w_o | output | 1 | Protocol currently in use |
| mode_gpio_o | output | 1 | Strap pin level when it is overridden |
| cs_gpio_o | output | 1 | Select pin level in 2-wire mode |

## Verification
The bench sends 3-wire windows that are short by four bits and long by one bit. A design that commits on any select edge would strobe a shifted word. It sends a wrong device address and a read request. A design that does not lock out until the next start would acknowledge the later bytes, or strobe a garbage word. A repeated start placed mid-word catches a counter that is not cleared, because that would merge the stale bytes into the next word. Toggling the strap while the override bit is set catches a protocol select that still follows the pin.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    typedef enum logic [1:0] {
        TW_IDLE = 2'd0,
        TW_RX   = 2'd1,
        TW_ACK  = 2'd2,
        TW_SKIP = 2'd3
    } tw_state_e;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_3w_rx.sv
module ctl_3w_rx #(
    parameter int WORD_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              csn_i,
    input  logic              cs_rise_i,
    input  logic              scl_rise_i,
    input  logic              sda_i,
    output logic              vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
    } st3_t;

    st3_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!en_i) begin
            s_d = '0;
        end else if (cs_rise_i) begin
            s_d.vld = (s_q.cnt == CNT_FULL);
            s_d.cnt = '0;
        end else if (csn_i) begin
            s_d.cnt = '0;
        end else if (scl_rise_i) begin
            s_d.sh = {s_q.sh[WORD_W-2:0], sda_i};
            if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign vld_o  = s_q.vld;
    assign word_o = s_q.sh;
endmodule

// File: rtl/ctl_2w_rx.sv
module ctl_2w_rx
    import ctl_pkg::*;
#(
    parameter int         WORD_W   = 24,
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              scl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    input  logic              sda_rise_i,
    input  logic              sda_fall_i,
    output logic              pull_o,
    output logic              vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int NBYTES = WORD_W / 8;
    localparam int IDX_W  = $clog2(NBYTES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES);
    localparam logic [7:0]       DEV_BYTE = {DEV_ADDR, 1'b0};

    typedef struct packed {
        tw_state_e         st;
        logic [WORD_W-1:0] sh;
        logic [3:0]        bit_cnt;
        logic [IDX_W-1:0]  byte_idx;
        logic              pull;
        logic              vld;
    } st2_t;

    localparam st2_t RST = '{st: TW_IDLE, sh: '0, bit_cnt: '0, byte_idx: '0,
                             pull: 1'b0, vld: 1'b0};

    st2_t s_d, s_q;
    logic start, stop;

    assign start = sda_fall_i & scl_i;
    assign stop  = sda_rise_i & scl_i;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!en_i) begin
            s_d = RST;
        end else if (start) begin
            s_d.st       = TW_RX;
            s_d.bit_cnt  = '0;
            s_d.byte_idx = '0;
            s_d.pull     = 1'b0;
        end else if (stop) begin
            s_d.st   = TW_IDLE;
            s_d.pull = 1'b0;
        end else begin
            case (s_q.st)
                TW_RX: begin
                    if (scl_rise_i && s_q.bit_cnt < 4'd8) begin
                        s_d.sh      = {s_q.sh[WORD_W-2:0], sda_i};
                        s_d.bit_cnt = s_q.bit_cnt + 4'd1;
                    end else if (scl_fall_i && s_q.bit_cnt == 4'd8) begin
                        s_d.bit_cnt = '0;
                        if (s_q.byte_idx == '0 && s_q.sh[7:0] != DEV_BYTE) begin
                            s_d.st = TW_SKIP;
                        end else begin
                            s_d.st   = TW_ACK;
                            s_d.pull = 1'b1;
                            s_d.vld  = (s_q.byte_idx == LAST_IDX);
                        end
                    end
                end
                TW_ACK: begin
                    if (scl_fall_i) begin
                        s_d.pull = 1'b0;
                        if (s_q.byte_idx == LAST_IDX) begin
                            s_d.st = TW_SKIP;
                        end else begin
                            s_d.byte_idx = s_q.byte_idx + 1'b1;
                            s_d.st       = TW_RX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= RST;
        else         s_q <= s_d;
    end

    assign pull_o = s_q.pull;
    assign vld_o  = s_q.vld;
    assign word_o = s_q.sh;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NREGS    = 16,
    parameter int CFG_ADDR = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cfg_bit_o
);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NREGS);

    logic [DATA_W-1:0] regs_d [NREGS];
    logic [DATA_W-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) regs_d[i] = regs_q[i];
        if (we_i && ({1'b0, waddr_i} < LIMIT))
            regs_d[waddr_i[IDX_W-1:0]] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata_o   = ({1'b0, raddr_i} < LIMIT) ? regs_q[raddr_i[IDX_W-1:0]] : '0;
    assign cfg_bit_o = regs_q[CFG_ADDR][0];
endmodule

// File: rtl/ctl_serial_slave.sv
module ctl_serial_slave #(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 16,
    parameter int         NREGS    = 16,
    parameter int         CFG_ADDR = 8,
    parameter logic [6:0] DEV_ADDR = 7'h1A,
    parameter int         SYNC_STG = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              csn_i,
    input  logic              mode_i,
    output logic              sda_pull_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              proto_3w_o,
    output logic              mode_gpio_o,
    output logic              cs_gpio_o
);
    localparam int WORD_W = ADDR_W + DATA_W;

    typedef struct packed {
        logic              scl_p;
        logic              sda_p;
        logic              cs_p;
        logic              proto_3w;
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } top_t;

    localparam top_t RST = '{scl_p: 1'b1, sda_p: 1'b1, cs_p: 1'b1, proto_3w: 1'b0,
                             stb: 1'b0, addr: '0, data: '0};

    logic [3:0] pins_s;
    logic scl_s, sda_s, cs_s, mode_s;
    logic gpio_en;
    logic vld3, vld2, pull2;
    logic [WORD_W-1:0] word3, word2, word_sel;
    top_t t_d, t_q;

    ctl_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b1110)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({scl_i, sda_i, csn_i, mode_i}),
        .q_o   (pins_s)
    );
    assign {scl_s, sda_s, cs_s, mode_s} = pins_s;

    ctl_3w_rx #(.WORD_W(WORD_W)) u_rx3 (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (t_q.proto_3w),
        .csn_i     (cs_s),
        .cs_rise_i (cs_s & ~t_q.cs_p),
        .scl_rise_i(scl_s & ~t_q.scl_p),
        .sda_i     (sda_s),
        .vld_o     (vld3),
        .word_o    (word3)
    );

    ctl_2w_rx #(.WORD_W(WORD_W), .DEV_ADDR(DEV_ADDR)) u_rx2 (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (~t_q.proto_3w),
        .scl_i     (scl_s),
        .scl_rise_i(scl_s & ~t_q.scl_p),
        .scl_fall_i(~scl_s & t_q.scl_p),
        .sda_i     (sda_s),
        .sda_rise_i(sda_s & ~t_q.sda_p),
        .sda_fall_i(~sda_s & t_q.sda_p),
        .pull_o    (pull2),
        .vld_o     (vld2),
        .word_o    (word2)
    );

    assign word_sel = t_q.proto_3w ? word3 : word2;

    always_comb begin
        t_d          = t_q;
        t_d.scl_p    = scl_s;
        t_d.sda_p    = sda_s;
        t_d.cs_p     = cs_s;
        t_d.proto_3w = gpio_en ? t_q.proto_3w : mode_s;
        t_d.stb      = (t_q.proto_3w & vld3) | (~t_q.proto_3w & vld2);
        if (t_d.stb) begin
            t_d.addr = word_sel[WORD_W-1 -: ADDR_W];
            t_d.data = word_sel[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= RST;
        else         t_q <= t_d;
    end

    ctl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .CFG_ADDR(CFG_ADDR)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (t_q.stb),
        .waddr_i  (t_q.addr),
        .wdata_i  (t_q.data),
        .raddr_i  (rd_addr_i),
        .rdata_o  (rd_data_o),
        .cfg_bit_o(gpio_en)
    );

    assign sda_pull_o  = pull2 & ~t_q.proto_3w;
    assign wr_stb_o    = t_q.stb;
    assign wr_addr_o   = t_q.addr;
    assign wr_data_o   = t_q.data;
    assign proto_3w_o  = t_q.proto_3w;
    assign mode_gpio_o = gpio_en & mode_s;
    assign cs_gpio_o   = ~t_q.proto_3w & cs_s;
endmodule

// File: rtl/ctl_serial_slave_chk.sv
module ctl_serial_slave_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NREGS  = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_stb_o,
    input logic              sda_pull_o,
    input logic              proto_3w_o,
    input logic              gpio_en,
    input logic              cs_gpio_o,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NREGS);

    // R9
    stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o |=> !wr_stb_o);

    // R5
    ack_only_2w_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_pull_o |-> !proto_3w_o);

    // R11
    proto_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gpio_en && $past(gpio_en)) |-> $stable(proto_3w_o));

    // R12
    cs_gpio_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        proto_3w_o |-> !cs_gpio_o);

    // R10
    rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, rd_addr_i} >= LIMIT) |-> (rd_data_o == '0));
endmodule

bind ctl_serial_slave ctl_serial_slave_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_o  (wr_stb_o),
    .sda_pull_o(sda_pull_o),
    .proto_3w_o(proto_3w_o),
    .gpio_en   (gpio_en),
    .cs_gpio_o (cs_gpio_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
);

// File: tb/ctl_serial_slave_tb.sv
`timescale 1ns/1ps
module ctl_serial_slave_tb;
    localparam int         HP  = 8;
    localparam logic [6:0] DEV = 7'h1A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, csn = 1'b1, mode = 1'b1;
    logic [7:0]  rd_addr = 8'd0;
    logic        sda_pull, wr_stb, proto_3w, mode_gpio, cs_gpio;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data, rd_data;
    logic        sda_line;
    int errors = 0, checks = 0;
    logic [23:0] exp_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    ctl_serial_slave u_dut (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .csn_i(csn),
        .mode_i(mode), .sda_pull_o(sda_pull), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .proto_3w_o(proto_3w), .mode_gpio_o(mode_gpio), .cs_gpio_o(cs_gpio)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R7 unexpected strobe", {8'h0, wr_addr, wr_data}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk({wr_addr, wr_data} == e, "R2/R6 strobe word", {8'h0, wr_addr, wr_data}, {8'h0, e});
            end
        end
    end

    task automatic w3(input logic [7:0] a, input logic [15:0] d, input int nbits);
        logic [31:0] v;
        v = {a, d, 8'h00};
        if (nbits == 24) exp_q.push_back({a, d});
        m_scl = 1'b0; cyc(HP);
        csn = 1'b0; cyc(HP);
        for (int i = 0; i < nbits; i++) begin
            m_sda = v[31-i]; cyc(HP);
            m_scl = 1'b1; cyc(HP);
            m_scl = 1'b0;
        end
        cyc(HP);
        csn = 1'b1; cyc(HP);
        m_sda = 1'b1; m_scl = 1'b1; cyc(2*HP);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; cyc(HP);
        m_scl = 1'b1; cyc(HP);
        m_sda = 1'b0; cyc(HP);
        m_scl = 1'b0; cyc(HP);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; cyc(HP);
        m_scl = 1'b1; cyc(HP);
        m_sda = 1'b1; cyc(2*HP);
    endtask

    task automatic i2c_byte(input logic [7:0] b, input bit ack_exp, input string req);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; cyc(HP);
            m_scl = 1'b1; cyc(HP);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; cyc(HP);
        chk(sda_pull == ack_exp, req, {31'h0, sda_pull}, {31'h0, ack_exp});
        m_scl = 1'b1; cyc(HP/2);
        chk(sda_pull == ack_exp, req, {31'h0, sda_pull}, {31'h0, ack_exp});
        cyc(HP/2);
        m_scl = 1'b0; cyc(HP);
        chk(sda_pull == 1'b0, "R5 ack release", {31'h0, sda_pull}, 32'h0);
    endtask

    task automatic i2c_write(input logic [7:0] a, input logic [15:0] d);
        exp_q.push_back({a, d});
        i2c_start();
        i2c_byte({DEV, 1'b0}, 1'b1, "R5 device ack");
        i2c_byte(a, 1'b1, "R6 addr ack");
        i2c_byte(d[15:8], 1'b1, "R6 data hi ack");
        i2c_byte(d[7:0], 1'b1, "R6 data lo ack");
        i2c_stop();
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] e, input string req);
        rd_addr = a; cyc(2);
        chk(rd_data == e, req, {16'h0, rd_data}, {16'h0, e});
    endtask

    initial begin
        cyc(5);
        // R1 reset state
        chk(wr_stb == 1'b0, "R1 strobe idle", {31'h0, wr_stb}, 32'h0);
        chk(sda_pull == 1'b0, "R1 pull idle", {31'h0, sda_pull}, 32'h0);
        rd_chk(8'd3, 16'h0, "R1 reg zero");
        rst_n = 1'b1; cyc(10);
        chk(proto_3w == 1'b1, "R4 strap high 3-wire", {31'h0, proto_3w}, 32'h1);
        chk(cs_gpio == 1'b0, "R12 cs gpio in 3-wire", {31'h0, cs_gpio}, 32'h0);

        // R2 3-wire write
        w3(8'h03, 16'hBEEF, 24);
        rd_chk(8'h03, 16'hBEEF, "R2/R10 3-wire stored");
        // R3 short and long windows
        w3(8'h03, 16'h1111, 20);
        w3(8'h03, 16'h2222, 25);
        rd_chk(8'h03, 16'hBEEF, "R3 bad length discarded");
        // R10 out of range write
        w3(8'h40, 16'h1234, 24);
        rd_chk(8'h40, 16'h0000, "R10 high addr reads 0");
        rd_chk(8'h00, 16'h0000, "R10 no alias write");
        rd_chk(8'h03, 16'hBEEF, "R10 other reg kept");

        // R4 switch to 2-wire
        mode = 1'b0; cyc(10);
        chk(proto_3w == 1'b0, "R4 strap low 2-wire", {31'h0, proto_3w}, 32'h0);
        i2c_write(8'h05, 16'hCAFE);
        rd_chk(8'h05, 16'hCAFE, "R6 2-wire stored");

        // R12 select pin as general input
        csn = 1'b0; cyc(6);
        chk(cs_gpio == 1'b0, "R12 cs gpio low", {31'h0, cs_gpio}, 32'h0);
        csn = 1'b1; cyc(6);
        chk(cs_gpio == 1'b1, "R12 cs gpio high", {31'h0, cs_gpio}, 32'h1);

        // R7 wrong device and read request
        i2c_start();
        i2c_byte({DEV ^ 7'h01, 1'b0}, 1'b0, "R7 wrong device no ack");
        i2c_byte(8'h05, 1'b0, "R7 ignored byte");
        i2c_byte(8'h00, 1'b0, "R7 ignored byte");
        i2c_byte(8'h00, 1'b0, "R7 ignored byte");
        i2c_stop();
        i2c_start();
        i2c_byte({DEV, 1'b1}, 1'b0, "R7 read bit no ack");
        i2c_stop();
        rd_chk(8'h05, 16'hCAFE, "R7 reg unchanged");

        // R8 repeated start mid-word
        exp_q.push_back({8'h07, 16'h55AA});
        i2c_start();
        i2c_byte({DEV, 1'b0}, 1'b1, "R8 first dev ack");
        i2c_byte(8'h06, 1'b1, "R8 partial addr ack");
        i2c_byte(8'h12, 1'b1, "R8 partial data ack");
        i2c_start();
        i2c_byte({DEV, 1'b0}, 1'b1, "R8 restart dev ack");
        i2c_byte(8'h07, 1'b1, "R8 addr ack");
        i2c_byte(8'h55, 1'b1, "R8 data hi ack");
        i2c_byte(8'hAA, 1'b1, "R8 data lo ack");
        i2c_stop();
        rd_chk(8'h06, 16'h0000, "R8 partial word dropped");
        rd_chk(8'h07, 16'h55AA, "R8 new word stored");

        // R11 strap override
        i2c_write(8'h08, 16'h0001);
        cyc(4);
        mode = 1'b1; cyc(10);
        chk(proto_3w == 1'b0, "R11 protocol frozen", {31'h0, proto_3w}, 32'h0);
        chk(mode_gpio == 1'b1, "R11 strap as input high", {31'h0, mode_gpio}, 32'h1);
        mode = 1'b0; cyc(10);
        chk(mode_gpio == 1'b0, "R11 strap as input low", {31'h0, mode_gpio}, 32'h0);
        i2c_write(8'h08, 16'h0000);
        cyc(4);
        chk(mode_gpio == 1'b0, "R11 gpio released", {31'h0, mode_gpio}, 32'h0);
        mode = 1'b1; cyc(10);
        chk(proto_3w == 1'b1, "R11 strap control back", {31'h0, proto_3w}, 32'h1);

        cyc(20);
        chk(exp_q.size() == 0, "R2/R6 missing strobes", exp_q.size(), 32'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule